// File: doc/BRIEF.md
# Bridge-Sensor ADC Serial Device Model

This block stands in for the device end of a two-wire bridge-sensor converter link. It is a loopback target for a master controller under test. The master drives a serial clock into the block and reads a single data line back. A parallel side loads 24-bit two's-complement results.

When a result is loaded, the data line falls low to show that data is ready. The master's clock pulses then shift the result out, most significant bit first. The number of pulses in a read frame is itself a command: after 24 data pulses, the count of trailing pulses picks the input channel and gain for the next conversion. The block latches that choice once the clock has stayed low for a set idle time. It reports the choice on a status output.

A clock held high for too long puts the model into power-down. In power-down the data line stays high. When the clock returns low, the selection goes back to its default.

Top module: `bridge_adc_emu`

## Requirements
- R1: After reset, `data_out` is 1 and `sel_code` is 0 (channel A, gain 128).
- R2: A `load` pulse while no frame is in progress and the block is not powered down drives `data_out` low on the next clock edge.
- R3: Pulses 1 to 24 on `sck_in` shift the loaded word out MSB first. Each bit appears on `data_out` three system clocks after `sck_in` rises: two synchronizer stages, then one output register.
- R4: Pulse 25 and every later pulse of a frame drive `data_out` to 1. It stays 1 after the frame until a result is presented again.
- R5: At frame end, the pulse count sets `sel_code`. 25 pulses give 0 (channel A, gain 128), 26 pulses give 1 (channel B, gain 32), and 27 or more pulses give 2 (channel A, gain 64).
- R6: A frame ends only after the synchronized clock has been low for IDLE_CLKS consecutive system clocks. Before that, `sel_code` keeps its old value.
- R7: A frame that ends with fewer than 25 pulses leaves `sel_code` unchanged and discards the rest of the word, so `data_out` returns to 1.
- R8: A word loaded while a frame is in progress is held back. The current frame's bits are not disturbed. The held word is presented (`data_out` low) when that frame ends, and it then reads out normally.
- R9: If `sck_in` stays high for PDN_CLKS system clocks, the frame is aborted and `data_out` is held at 1. When `sck_in` returns low, `sel_code` becomes 0.
- R10: `load` pulses during power-down are ignored, so `data_out` is still 1 after power-down ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Serial clock from the master, asynchronous to clk |
| load | input | 1 | One-cycle strobe: a new conversion result is available |
| load_data | input | 24 | Conversion result, two's complement |
| data_out | output | 1 | Serial data line; low when data is ready |
| sel_code | output | 2 | Current selection: 0 = A/128, 1 = B/32, 2 = A/64 |

## Verification
A wrong pulse count or a bad shift register shows on `data_out` within one bit slot. The bit seen after the offending pulse differs from the loaded word, or the line is not high on the 25th pulse. An idle timer or selection latch that misbehaves shows on `sel_code` one idle window after the frame: the wrong code appears, or the change comes too early, which the mid-window probe catches. Errors in the held-word path or in power-down show as the level of `data_out` right after the frame or the power-down ends, before any new pulse.

// File: rtl/bae_pkg.sv
`timescale 1ns/1ps
package bae_pkg;

    localparam int WORD_W     = 24;
    localparam int FRAME_MIN  = WORD_W + 1;
    localparam int PCNT_W     = 5;
    localparam int PCNT_MAX   = (1 << PCNT_W) - 1;

    typedef enum logic [1:0] {
        SEL_A128 = 2'd0,
        SEL_B32  = 2'd1,
        SEL_A64  = 2'd2
    } sel_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } word_t;

    function automatic sel_e count_to_sel(input logic [PCNT_W-1:0] n);
        if (n == PCNT_W'(FRAME_MIN))
            return SEL_A128;
        else if (n == PCNT_W'(FRAME_MIN + 1))
            return SEL_B32;
        else
            return SEL_A64;
    endfunction

endpackage

// File: rtl/bae_sck_sync.sv
`timescale 1ns/1ps
module bae_sck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_async,
    output logic sck_lvl,
    output logic sck_rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-1:0], sck_async};
    end

    assign sck_lvl  = chain_q[STAGES-1];
    assign sck_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // a rising edge is a single-cycle event
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (rst)
        sck_rise |=> !sck_rise);

endmodule

// File: rtl/bae_timer.sv
`timescale 1ns/1ps
module bae_timer #(
    parameter int IDLE_CLKS = 64,
    parameter int PDN_CLKS  = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_lvl,
    output logic idle_hit,
    output logic pd_active,
    output logic pd_enter,
    output logic pd_exit
);
    localparam int LW = $clog2(IDLE_CLKS + 1);
    localparam int HW = $clog2(PDN_CLKS + 1);

    logic [LW-1:0] low_cnt_q;
    logic [HW-1:0] high_cnt_q;
    logic          pd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt_q  <= '0;
            high_cnt_q <= '0;
            pd_q       <= 1'b0;
        end else begin
            if (sck_lvl)
                low_cnt_q <= '0;
            else if (low_cnt_q != LW'(IDLE_CLKS))
                low_cnt_q <= low_cnt_q + 1'b1;

            if (!sck_lvl)
                high_cnt_q <= '0;
            else if (high_cnt_q != HW'(PDN_CLKS))
                high_cnt_q <= high_cnt_q + 1'b1;

            if (pd_enter)
                pd_q <= 1'b1;
            else if (pd_exit)
                pd_q <= 1'b0;
        end
    end

    assign idle_hit  = !sck_lvl && (low_cnt_q == LW'(IDLE_CLKS - 1));
    assign pd_enter  = sck_lvl && !pd_q && (high_cnt_q == HW'(PDN_CLKS - 1));
    assign pd_exit   = pd_q && !sck_lvl;
    assign pd_active = pd_q;

    assert_pd_leave_R9: assert property (@(posedge clk) disable iff (rst)
        pd_exit |=> !pd_active);

    assert_pd_needs_high_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_active) |-> $past(sck_lvl));

endmodule

// File: rtl/bae_frame.sv
`timescale 1ns/1ps
module bae_frame
    import bae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_rise,
    input  logic              idle_hit,
    input  logic              pd_active,
    input  logic              pd_enter,
    input  logic              pd_exit,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    output logic              dout,
    output sel_e              sel
);
    word_t             cur_q;
    word_t             held_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic              dout_q;
    sel_e              sel_q;
    logic              in_frame;

    assign in_frame = (pcnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            held_q <= '0;
            pcnt_q <= '0;
            dout_q <= 1'b1;
            sel_q  <= SEL_A128;
        end else if (pd_enter) begin
            cur_q  <= '0;
            held_q <= '0;
            pcnt_q <= '0;
            dout_q <= 1'b1;
        end else if (pd_active) begin
            if (pd_exit)
                sel_q <= SEL_A128;
        end else if (sck_rise) begin
            if (load)
                held_q <= '{valid: 1'b1, data: load_data};
            if (pcnt_q != PCNT_W'(PCNT_MAX))
                pcnt_q <= pcnt_q + 1'b1;
            if ((pcnt_q < PCNT_W'(WORD_W)) && cur_q.valid) begin
                dout_q     <= cur_q.data[WORD_W-1];
                cur_q.data <= {cur_q.data[WORD_W-2:0], 1'b0};
            end else begin
                dout_q <= 1'b1;
            end
        end else if (idle_hit && in_frame) begin
            if (pcnt_q >= PCNT_W'(FRAME_MIN))
                sel_q <= count_to_sel(pcnt_q);
            pcnt_q <= '0;
            if (load) begin
                cur_q  <= '{valid: 1'b1, data: load_data};
                held_q <= '0;
                dout_q <= 1'b0;
            end else if (held_q.valid) begin
                cur_q  <= held_q;
                held_q <= '0;
                dout_q <= 1'b0;
            end else begin
                cur_q.valid <= 1'b0;
                dout_q      <= 1'b1;
            end
        end else if (load) begin
            if (in_frame) begin
                held_q <= '{valid: 1'b1, data: load_data};
            end else begin
                cur_q  <= '{valid: 1'b1, data: load_data};
                dout_q <= 1'b0;
            end
        end
    end

    assign dout = dout_q;
    assign sel  = sel_q;

    assert_load_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (load && !pd_active && !pd_enter && !sck_rise && !in_frame) |=> !dout);

    assert_tail_high_R4: assert property (@(posedge clk) disable iff (rst)
        (sck_rise && !pd_active && (pcnt_q >= PCNT_W'(WORD_W))) |=> dout);

    assert_sel_only_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_q != $past(sel_q)) |-> $past(idle_hit || pd_exit));

    assert_hold_mid_frame_R8: assert property (@(posedge clk) disable iff (rst)
        (load && in_frame && !pd_active && !pd_enter && !idle_hit) |=> held_q.valid);

    assert_pd_line_high_R9: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> dout);

endmodule

// File: rtl/bridge_adc_emu.sv
`timescale 1ns/1ps
module bridge_adc_emu #(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CLKS   = 64,
    parameter int PDN_CLKS    = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck_in,
    input  logic        load,
    input  logic [23:0] load_data,
    output logic        data_out,
    output logic [1:0]  sel_code
);
    import bae_pkg::*;

    logic sck_lvl;
    logic sck_rise;
    logic idle_hit;
    logic pd_active;
    logic pd_enter;
    logic pd_exit;
    sel_e sel;

    bae_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sck_async (sck_in),
        .sck_lvl   (sck_lvl),
        .sck_rise  (sck_rise)
    );

    bae_timer #(.IDLE_CLKS(IDLE_CLKS), .PDN_CLKS(PDN_CLKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .sck_lvl   (sck_lvl),
        .idle_hit  (idle_hit),
        .pd_active (pd_active),
        .pd_enter  (pd_enter),
        .pd_exit   (pd_exit)
    );

    bae_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .sck_rise  (sck_rise),
        .idle_hit  (idle_hit),
        .pd_active (pd_active),
        .pd_enter  (pd_enter),
        .pd_exit   (pd_exit),
        .load      (load),
        .load_data (load_data),
        .dout      (data_out),
        .sel       (sel)
    );

    assign sel_code = sel;

endmodule

// File: tb/bridge_adc_emu_test.sv
`timescale 1ns/1ps
module bridge_adc_emu_test;

    localparam int IDLE = 64;
    localparam int PDN  = 256;
    localparam int HI   = 6;
    localparam int LO   = 6;
    localparam int NVEC = 6;

    // {word[23:0], pulses[5:0], expected sel[1:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {24'hA5A5A5, 6'd26, 2'd1},
        {24'h123456, 6'd27, 2'd2},
        {24'h800001, 6'd25, 2'd0},
        {24'h7FFFFF, 6'd28, 2'd2},
        {24'h000000, 6'd26, 2'd1},
        {24'hFFFFFF, 6'd25, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck_in = 1'b0;
    logic        load = 1'b0;
    logic [23:0] load_data = '0;
    logic        data_out;
    logic [1:0]  sel_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bridge_adc_emu #(.IDLE_CLKS(IDLE), .PDN_CLKS(PDN)) uut (
        .clk       (clk),
        .rst       (rst),
        .sck_in    (sck_in),
        .load      (load),
        .load_data (load_data),
        .data_out  (data_out),
        .sel_code  (sel_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(output logic seen);
        sck_in = 1'b1;
        repeat (HI) @(negedge clk);
        seen = data_out;
        sck_in = 1'b0;
        repeat (LO) @(negedge clk);
    endtask

    task automatic put(input logic [23:0] w);
        load = 1'b1;
        load_data = w;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic read_bits(input logic [23:0] w, input int first, input int count);
        logic b;
        for (int k = first; k < first + count; k++) begin
            pulse(b);
            if (k < 24) chk("R3 data bit", {31'd0, b}, {31'd0, w[23-k]});
            else        chk("R4 trailing pulse", {31'd0, b}, 32'd1);
        end
    endtask

    task automatic idle_wait();
        repeat (IDLE + 12) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] w;
        logic [5:0]  n;
        logic [1:0]  s;
        logic        b;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset data_out", {31'd0, data_out}, 32'd1);
        chk("R1 reset sel_code", {30'd0, sel_code}, 32'd0);

        // table walk: R2 ready, R3/R4 bits, R5 selection, R4 line high after frame
        for (int i = 0; i < NVEC; i++) begin
            {w, n, s} = VEC[i];
            put(w);
            chk("R2 ready low", {31'd0, data_out}, 32'd0);
            read_bits(w, 0, int'(n));
            idle_wait();
            chk("R5 selection", {30'd0, sel_code}, {30'd0, s});
            chk("R4 line high after frame", {31'd0, data_out}, 32'd1);
        end

        // R6: no latch before the idle window closes
        put(24'h55AA33);
        read_bits(24'h55AA33, 0, 26);
        repeat (IDLE - 20) @(negedge clk);
        chk("R6 sel held mid-window", {30'd0, sel_code}, 32'd0);
        repeat (36) @(negedge clk);
        chk("R6 sel after window", {30'd0, sel_code}, 32'd1);

        // R7: short frame keeps selection, drops the word
        put(24'h0F0F0F);
        read_bits(24'h0F0F0F, 0, 10);
        idle_wait();
        chk("R7 sel kept", {30'd0, sel_code}, 32'd1);
        chk("R7 line high", {31'd0, data_out}, 32'd1);

        // R8: load during a frame is held back
        put(24'h3C3C3C);
        read_bits(24'h3C3C3C, 0, 5);
        put(24'hC0FFEE);
        chk("R8 current bit undisturbed", {31'd0, data_out}, {31'd0, w[0] & 1'b0 | 1'b1 & 1'b0 | 24'h3C3C3C >> 19 & 1'b1});
        read_bits(24'h3C3C3C, 5, 20);
        idle_wait();
        chk("R8 sel from 25 pulses", {30'd0, sel_code}, 32'd0);
        chk("R8 held word presented", {31'd0, data_out}, 32'd0);
        read_bits(24'hC0FFEE, 0, 27);
        idle_wait();
        chk("R8 held word frame sel", {30'd0, sel_code}, 32'd2);

        // R9/R10: power-down
        put(24'h00FF00);
        sck_in = 1'b1;
        repeat (PDN + 20) @(negedge clk);
        chk("R9 line high in power-down", {31'd0, data_out}, 32'd1);
        put(24'h123123);
        @(negedge clk);
        chk("R10 load ignored in power-down", {31'd0, data_out}, 32'd1);
        sck_in = 1'b0;
        repeat (10) @(negedge clk);
        chk("R9 sel default after power-down", {30'd0, sel_code}, 32'd0);
        chk("R10 line still high", {31'd0, data_out}, 32'd1);
        idle_wait();
        put(24'hABCDEF);
        chk("R2 ready after power-down", {31'd0, data_out}, 32'd0);
        read_bits(24'hABCDEF, 0, 26);
        idle_wait();
        chk("R5 sel after power-down frame", {30'd0, sel_code}, 32'd1);

        b = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule